// File: doc/BRIEF.md
# Three-Channel PWM Timer/Counter

This block is a 16-bit timer/counter that paces itself from a selectable clock divider and drives three waveform pins. A 2-bit mode field picks one of four counting schemes: free-running up-count over the full range, up-count cleared at a programmable limit, single-slope PWM that wraps at that limit, and dual-slope PWM that climbs to the limit and then descends back to zero. Each channel compares the count against its own threshold. On a match it sets, clears or toggles its waveform bit, and the effect of each action code depends on the counting scheme.

Software reaches the block through a small word-wide register port. That port holds a control word, the count itself, three compare thresholds and the limit (TOP). In both PWM schemes a new threshold waits in a staging register and takes effect only when the count sits at TOP. In the two non-PWM schemes it takes effect at once. Each pin takes its waveform bit in place of the ordinary port value whenever its channel action code is non-zero. A pin is driven only while its direction input is high.

Top module: `pwmt_top`

## Requirements
- R1: After the active-low asynchronous reset, every register reads 0, all three pins output 0, and both strobes are low.
- R2: Control bits 9:8 choose the count enable. 00 stops the counter. 01 advances it every clock. 10 advances it when the low 3 bits of a free-running 6-bit divider (cleared by reset) are all ones, which is every 8th clock. 11 advances it when all 6 divider bits are ones, which is every 64th clock.
- R3: With control bits 1:0 = 00 (free run), the count goes from 65535 to 0 and raises the overflow strobe.
- R4: With bits 1:0 = 01 (clear at limit) or 10 (single-slope PWM), an advance taken at count == TOP loads 0 and raises the overflow strobe. This gives TOP-1, TOP, 0, 1.
- R5: With bits 1:0 = 11 (dual-slope PWM), the count turns downward at TOP, giving TOP-1, TOP, TOP-1. It turns upward again at 0 and raises the overflow strobe there. TOP must be at least 2.
- R6: The overflow strobe and the per-channel match strobes are high for exactly the one clock that follows the advance which caused them. A match is an advance taken while the count equals that channel's active threshold.
- R7: Register addresses are 0 control, 1 count, 2/3/4 thresholds of channels A/B/C, and 5 TOP. A threshold read returns the last value written. In PWM schemes the active threshold copies the staged value on an advance at count == TOP. In non-PWM schemes it follows a write at once.
- R8: In the non-PWM schemes, action codes 01, 10 and 11 toggle, clear and set the waveform bit on a match. The action codes of channels A, B and C sit in control bits 7:6, 5:4 and 3:2.
- R9: In single-slope PWM, code 10 clears on a match and sets at the wrap to 0. Code 11 sets on a match and clears at the wrap. The wrap wins when both fall on the same advance. Code 01 toggles on a match.
- R10: In dual-slope PWM, code 10 clears on a match taken while counting up and sets on a match taken while counting down. Code 11 does the opposite. Code 01 toggles.
- R11: A pin outputs the waveform bit when its action code is non-zero and the port input otherwise. The output enable equals the direction input, and the pin outputs 0 when its direction input is low.
- R12: A write to the count takes priority over an advance on the same clock. It also suppresses every compare match on the next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the addressed register (combinational) |
| portIn | input | 3 | Ordinary port values for pins A, B, C |
| pinDir | input | 3 | Direction bits; 1 drives the pin |
| pinOut | output | 3 | Pin values |
| pinOe | output | 3 | Pin output enables |
| ovfFlag | output | 1 | One-clock overflow strobe |
| matchFlag | output | 3 | One-clock compare-match strobes for A, B, C |

## Verification
The count is run in every scheme across its turning points. Free running is started just below 65535 so the full-range wrap is reached. The clear-at-limit scheme is given a small TOP and three thresholds with distinct actions, which separates toggle, clear and set. Single-slope and dual-slope PWM are run with one threshold equal to TOP and one threshold rewritten mid-period. These runs tell apart a staged threshold from an immediate one, a wrap from a reversal, and the up-match from the down-match. All three divider settings are applied, and the stopped setting too. Pin direction and port values change pseudo-randomly each clock. A count write onto a threshold shows the match suppression.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  localparam int N_CH  = 3;
  localparam int ADR_W = 3;

  localparam logic [ADR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADR_W-1:0] ADR_CNT  = 3'd1;
  localparam int               ADR_CMP0 = 2;
  localparam logic [ADR_W-1:0] ADR_TOP  = 3'd5;

  typedef enum logic [1:0] {
    WM_FREE   = 2'b00,
    WM_CLRCMP = 2'b01,
    WM_FAST   = 2'b10,
    WM_DUAL   = 2'b11
  } waveMode_e;

  // strobes from the count control to the datapath
  typedef struct packed {
    logic tick;     // count advances this clock
    logic atTop;    // advance taken at count == TOP
    logic wrapEvt;  // single-slope reload to zero
    logic ovfEvt;   // overflow event for the flag
    logic down;     // dual-slope direction (1 = descending)
    logic matchOk;  // compare matches allowed on this advance
  } strobe_t;

endpackage

// File: rtl/pwmt_ctrl.sv
module pwmt_ctrl
  import pwmt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DIV_MID = 8,
  parameter int DIV_HI  = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       clkSel,
  input  waveMode_e        waveMode,
  input  logic [CNT_W-1:0] topVal,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  output logic [CNT_W-1:0] cntVal,
  output strobe_t          stb
);

  localparam int PRE_W = $clog2(DIV_HI);
  localparam int MID_W = $clog2(DIV_MID);

  logic [PRE_W-1:0] preCnt;
  logic             tick;
  logic             dirDown;
  logic             suppress;
  logic             dual;
  logic [CNT_W-1:0] wrapPt;
  logic [CNT_W-1:0] cntNxt;
  logic             downNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    unique case (clkSel)
      2'b00:   tick = 1'b0;
      2'b01:   tick = 1'b1;
      2'b10:   tick = &preCnt[MID_W-1:0];
      default: tick = &preCnt;
    endcase
  end

  assign dual   = (waveMode == WM_DUAL);
  assign wrapPt = (waveMode == WM_FREE) ? '1 : topVal;

  always_comb begin
    cntNxt  = cntVal + CNT_W'(1);
    downNxt = 1'b0;
    if (dual) begin
      downNxt = dirDown;
      if (!dirDown && cntVal == topVal) begin
        cntNxt  = topVal - CNT_W'(1);
        downNxt = 1'b1;
      end else if (dirDown && cntVal == '0) begin
        cntNxt  = CNT_W'(1);
        downNxt = 1'b0;
      end else if (dirDown) begin
        cntNxt  = cntVal - CNT_W'(1);
      end
    end else if (cntVal == wrapPt) begin
      cntNxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal   <= '0;
      suppress <= 1'b0;
    end else if (cntWrEn) begin
      cntVal   <= cntWrData;
      suppress <= 1'b1;
    end else if (tick) begin
      cntVal   <= cntNxt;
      suppress <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     dirDown <= 1'b0;
    else if (!dual)                dirDown <= 1'b0;
    else if (tick && !cntWrEn)     dirDown <= downNxt;
  end

  assign stb.tick    = tick;
  assign stb.atTop   = tick && (cntVal == topVal);
  assign stb.wrapEvt = tick && !dual && (cntVal == wrapPt);
  assign stb.ovfEvt  = stb.wrapEvt || (tick && dual && dirDown && cntVal == '0);
  assign stb.down    = dirDown;
  assign stb.matchOk = !suppress;

endmodule

// File: rtl/pwmt_dpath.sv
module pwmt_dpath
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [ADR_W-1:0] regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  input  logic [CNT_W-1:0] cntVal,
  input  strobe_t          stb,
  input  logic [N_CH-1:0]  portIn,
  input  logic [N_CH-1:0]  pinDir,
  output logic [N_CH-1:0]  pinOut,
  output logic [N_CH-1:0]  pinOe,
  output logic             ovfFlag,
  output logic [N_CH-1:0]  matchFlag,
  output logic [1:0]       clkSel,
  output waveMode_e        waveMode,
  output logic [CNT_W-1:0] topVal,
  output logic             cntWrEn,
  output logic [CNT_W-1:0] cntWrData
);

  localparam int CTRL_W = 10;

  logic [CTRL_W-1:0]      ctrlReg;
  logic [N_CH*CNT_W-1:0]  bufFlat;
  logic                   isPwm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      topVal  <= '0;
      ovfFlag <= 1'b0;
    end else begin
      ovfFlag <= stb.ovfEvt;
      if (regWrEn && regAddr == ADR_CTRL) ctrlReg <= regWrData[CTRL_W-1:0];
      if (regWrEn && regAddr == ADR_TOP)  topVal  <= regWrData;
    end
  end

  assign clkSel    = ctrlReg[9:8];
  assign waveMode  = waveMode_e'(ctrlReg[1:0]);
  assign isPwm     = ctrlReg[1];
  assign cntWrEn   = regWrEn && (regAddr == ADR_CNT);
  assign cntWrData = regWrData;
  assign pinOe     = pinDir;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [1:0]       fld;
    logic             wrCmp;
    logic [CNT_W-1:0] cmpBuf;
    logic [CNT_W-1:0] cmpAct;
    logic             hit;
    logic             hitQ;
    logic             wave;
    logic             waveNxt;

    assign fld   = ctrlReg[7-2*ch -: 2];
    assign wrCmp = regWrEn && (regAddr == ADR_W'(ADR_CMP0 + ch));
    assign hit   = stb.tick && stb.matchOk && (cntVal == cmpAct);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpBuf <= '0;
        cmpAct <= '0;
        hitQ   <= 1'b0;
      end else begin
        hitQ <= hit;
        if (wrCmp) cmpBuf <= regWrData;
        if (!isPwm && wrCmp)     cmpAct <= regWrData;
        else if (isPwm && stb.atTop) cmpAct <= cmpBuf;
      end
    end

    always_comb begin
      waveNxt = wave;
      if (fld == 2'b01) begin
        if (hit) waveNxt = !wave;
      end else if (fld != 2'b00) begin
        unique case (waveMode)
          WM_FAST: begin
            if (stb.wrapEvt) waveNxt = !fld[0];
            else if (hit)    waveNxt = fld[0];
          end
          WM_DUAL: begin
            if (hit) waveNxt = stb.down ? !fld[0] : fld[0];
          end
          default: begin
            if (hit) waveNxt = fld[0];
          end
        endcase
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wave <= 1'b0;
      else       wave <= waveNxt;
    end

    assign bufFlat[ch*CNT_W +: CNT_W] = cmpBuf;
    assign matchFlag[ch] = hitQ;
    assign pinOut[ch]    = pinDir[ch] & ((fld != 2'b00) ? wave : portIn[ch]);
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADR_CTRL)     regRdData = CNT_W'(ctrlReg);
    else if (regAddr == ADR_CNT) regRdData = cntVal;
    else if (regAddr == ADR_TOP) regRdData = topVal;
    for (int i = 0; i < N_CH; i++) begin
      if (regAddr == ADR_W'(ADR_CMP0 + i)) regRdData = bufFlat[i*CNT_W +: CNT_W];
    end
  end

endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
  import pwmt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DIV_MID = 8,
  parameter int DIV_HI  = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  input  logic [2:0]       portIn,
  input  logic [2:0]       pinDir,
  output logic [2:0]       pinOut,
  output logic [2:0]       pinOe,
  output logic             ovfFlag,
  output logic [2:0]       matchFlag
);

  logic [CNT_W-1:0] cntVal;
  strobe_t          stb;
  logic [1:0]       clkSel;
  waveMode_e        waveMode;
  logic [CNT_W-1:0] topVal;
  logic             cntWrEn;
  logic [CNT_W-1:0] cntWrData;

  pwmt_ctrl #(.CNT_W(CNT_W), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .waveMode(waveMode),
    .topVal(topVal), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cntVal(cntVal), .stb(stb)
  );

  pwmt_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cntVal(cntVal),
    .stb(stb), .portIn(portIn), .pinDir(pinDir), .pinOut(pinOut),
    .pinOe(pinOe), .ovfFlag(ovfFlag), .matchFlag(matchFlag),
    .clkSel(clkSel), .waveMode(waveMode), .topVal(topVal),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData)
  );

endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             down,
  input logic             cntWrEn,
  input logic [1:0]       clkSel,
  input logic [1:0]       waveMode,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] topVal,
  input logic             ovfFlag
);

  // R2: a stopped divider with no write leaves the count unchanged
  p_stall_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clkSel) == 2'b00 && !$past(cntWrEn)) |-> cntVal == $past(cntVal));

  // R3: full-range wrap in free-run scheme raises overflow
  p_free_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(tick && !cntWrEn && waveMode == 2'b00 && cntVal == '1)
      |-> (cntVal == '0 && ovfFlag));

  // R4: single-slope schemes reload zero after TOP
  p_single_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(tick && !cntWrEn && (waveMode == 2'b01 || waveMode == 2'b10) && cntVal == topVal)
      |-> cntVal == '0);

  // R5: dual-slope turns downward at TOP
  p_peak_turn_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(tick && !cntWrEn && waveMode == 2'b11 && !down && cntVal == topVal && topVal > 1)
      |-> (cntVal == $past(topVal) - CNT_W'(1) && down));

  // R6: overflow strobe only follows an advance
  p_ovf_after_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> $past(tick));

endmodule

bind pwmt_top pwmt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(stb.tick), .down(stb.down),
  .cntWrEn(cntWrEn), .clkSel(clkSel), .waveMode(waveMode),
  .cntVal(cntVal), .topVal(topVal), .ovfFlag(ovfFlag)
);

// File: tb/sim_pwmt_top.sv
module sim_pwmt_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd1;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [2:0]  portIn = '0;
  logic [2:0]  pinDir = '0;
  logic [2:0]  pinOut;
  logic [2:0]  pinOe;
  logic        ovfFlag;
  logic [2:0]  matchFlag;

  always #10 clk = ~clk;

  pwmt_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .portIn(portIn),
    .pinDir(pinDir), .pinOut(pinOut), .pinOe(pinOe), .ovfFlag(ovfFlag),
    .matchFlag(matchFlag)
  );

  int vecs = 0;
  int errs = 0;
  bit done = 0;
  string curReq = "R1";
  int rdSel = 1;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int mPre = 0, mCnt = 0, mDown = 0, mSupp = 0, mCtrl = 0, mTop = 0, mOvf = 0;
  int mBuf[3] = '{0, 0, 0};
  int mAct[3] = '{0, 0, 0};
  int mWave[3] = '{0, 0, 0};
  int mHit[3] = '{0, 0, 0};

  task automatic check(string tag, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic modelStep(bit we, int adr, int dat);
    int sel, mode, nxt, nd, f;
    bit tick, dual, pwm, atTop, wrapEvt, ovf;
    int hit[3];
    int wv[3];
    sel  = (mCtrl >> 8) & 3;
    mode = mCtrl & 3;
    tick = (sel == 1) || (sel == 2 && mPre % 8 == 7) || (sel == 3 && mPre % 64 == 63);
    mPre = (mPre + 1) % 64;
    dual = (mode == 3);
    pwm  = (mode >= 2);
    atTop   = tick && mCnt == mTop;
    wrapEvt = tick && !dual && mCnt == ((mode == 0) ? 65535 : mTop);
    ovf     = wrapEvt || (tick && dual && mDown == 1 && mCnt == 0);
    if (dual) begin
      if (mDown == 0 && mCnt == mTop) begin nxt = (mTop + 65535) % 65536; nd = 1; end
      else if (mDown == 1 && mCnt == 0) begin nxt = 1; nd = 0; end
      else if (mDown == 1) begin nxt = mCnt - 1; nd = 1; end
      else begin nxt = (mCnt + 1) % 65536; nd = 0; end
    end else begin
      nxt = wrapEvt ? 0 : (mCnt + 1) % 65536;
      nd = 0;
    end
    for (int c = 0; c < 3; c++) begin
      f = (mCtrl >> (6 - 2*c)) & 3;
      hit[c] = (tick && mSupp == 0 && mCnt == mAct[c]) ? 1 : 0;
      wv[c] = mWave[c];
      if (f == 1) begin
        if (hit[c] == 1) wv[c] = 1 - mWave[c];
      end else if (f != 0) begin
        if (mode == 2) begin
          if (wrapEvt) wv[c] = (f == 2) ? 1 : 0;
          else if (hit[c] == 1) wv[c] = (f == 3) ? 1 : 0;
        end else if (mode == 3) begin
          if (hit[c] == 1) wv[c] = ((mDown == 1) == (f == 2)) ? 1 : 0;
        end else if (hit[c] == 1) wv[c] = (f == 3) ? 1 : 0;
      end
    end
    for (int c = 0; c < 3; c++) begin
      if (!pwm && we && adr == 2 + c) mAct[c] = dat;
      else if (pwm && atTop) mAct[c] = mBuf[c];
      if (we && adr == 2 + c) mBuf[c] = dat;
      mWave[c] = wv[c];
      mHit[c] = hit[c];
    end
    mOvf = ovf ? 1 : 0;
    if (we && adr == 0) mCtrl = dat & 16'h03FF;
    if (we && adr == 5) mTop = dat;
    if (!dual) mDown = 0;
    else if (tick && !(we && adr == 1)) mDown = nd;
    if (we && adr == 1) begin mCnt = dat; mSupp = 1; end
    else if (tick) begin mCnt = nxt; mSupp = 0; end
  endtask

  task automatic compareAll();
    int ra, exp, f, ev;
    ra = regAddr;
    case (ra)
      0: exp = mCtrl;
      1: exp = mCnt;
      2, 3, 4: exp = mBuf[ra - 2];
      5: exp = mTop;
      default: exp = 0;
    endcase
    check(curReq, "regRdData", regRdData, exp);
    check(curReq, "ovfFlag (R6)", ovfFlag, mOvf);
    for (int c = 0; c < 3; c++) begin
      f = (mCtrl >> (6 - 2*c)) & 3;
      ev = pinDir[c] ? ((f != 0) ? mWave[c] : portIn[c]) : 0;
      check(curReq, $sformatf("pinOut[%0d]", c), pinOut[c], ev);
      check(curReq, $sformatf("pinOe[%0d] R11", c), pinOe[c], pinDir[c]);
      check(curReq, $sformatf("matchFlag[%0d]", c), matchFlag[c], mHit[c]);
    end
  endtask

  task automatic cyc(bit we, int adr, int dat);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    portIn    = lfsr[2:0];
    pinDir    = lfsr[7:5] | 3'b010;
    regWrEn   = we;
    regAddr   = we ? 3'(adr) : 3'(rdSel);
    regWrData = 16'(dat);
    @(posedge clk);
    modelStep(we, adr, dat);
    @(negedge clk);
    if (!done) compareAll();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    curReq = "R1";
    check("R1", "pinOut", pinOut, 0);
    check("R1", "ovfFlag", ovfFlag, 0);
    check("R1", "matchFlag", matchFlag, 0);
    rstN = 1'b1;
    for (int a = 0; a < 6; a++) begin
      rdSel = a;
      cyc(0, 0, 0);
      check("R1", $sformatf("reg %0d", a), regRdData, 0);
    end
    rdSel = 1;

    // R3: free run through 65535
    curReq = "R3";
    cyc(1, 0, 16'h0100);
    cyc(1, 1, 16'hFFF0);
    idle(40);

    // R2: divider settings
    curReq = "R2";
    cyc(1, 0, 16'h0200); idle(60);
    cyc(1, 0, 16'h0300); idle(300);
    cyc(1, 0, 16'h0000); idle(20);
    check("R2", "stopped count", regRdData, mCnt);

    // R4 R8: clear-at-limit with toggle/clear/set
    curReq = "R4 R8";
    cyc(1, 5, 20);
    cyc(1, 2, 5); cyc(1, 3, 10); cyc(1, 4, 15);
    cyc(1, 0, 16'h0100 | (1 << 6) | (2 << 4) | (3 << 2) | 1);
    cyc(1, 1, 0);
    idle(90);

    // R7: non-PWM threshold follows write at once
    curReq = "R7";
    cyc(1, 2, 3);
    rdSel = 2; cyc(0, 0, 0);
    check("R7", "threshold readback", regRdData, 3);
    rdSel = 1; idle(30);

    // R9 R7: single-slope PWM with staged threshold
    curReq = "R9 R7";
    cyc(1, 5, 30);
    cyc(1, 2, 10); cyc(1, 3, 20); cyc(1, 4, 30);
    cyc(1, 0, 16'h0100 | (2 << 6) | (3 << 4) | (2 << 2) | 2);
    idle(75);
    cyc(1, 2, 25);
    idle(80);

    // R6: short period flags
    curReq = "R6";
    cyc(1, 5, 5);
    idle(30);

    // R5 R10: dual-slope PWM
    curReq = "R5 R10";
    cyc(1, 5, 25);
    cyc(1, 2, 8); cyc(1, 3, 15); cyc(1, 4, 25);
    cyc(1, 0, 16'h0100 | (2 << 6) | (3 << 4) | (1 << 2) | 3);
    cyc(1, 1, 0);
    idle(150);
    cyc(1, 0, 16'h0200 | (3 << 6) | (2 << 4) | (2 << 2) | 3);
    idle(500);

    // R11: channel A released to port value
    curReq = "R11";
    cyc(1, 0, 16'h0100 | (0 << 6) | (2 << 4) | (1 << 2) | 1);
    cyc(1, 5, 40);
    idle(60);

    // R12: count write onto threshold suppresses next match
    curReq = "R12";
    cyc(1, 0, 16'h0100 | (1 << 6) | 1);
    cyc(1, 2, 12);
    cyc(1, 1, 12);
    cyc(0, 0, 0);
    check("R12", "suppressed match A", matchFlag[0], 0);
    idle(60);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule